// File: doc/BRIEF.md
# Stop-State Entry and Wake Controller

This block governs the deepest low-power state of a processor core. When the instruction decoder raises a stop request, the block checks the stop-disable flag. If the flag is clear, the block enters the stopped state and removes the clock enable from all internal logic. While stopped, it watches three active-low wake pins: a maskable interrupt, a high-priority interrupt and a reset pin. Each pin passes through a two-flop synchronizer.

When a wake is accepted, the block may first run a restart delay so that the oscillator can settle. It then re-enables the core clock and pulses a done strobe for one cycle, together with a 2-bit resume code. The code tells the core whether to stack and service the interrupt, carry on at the instruction after the stop, or fetch the reset vector.

The wake result depends on the source and on its mask flag. The high-priority interrupt always wakes the block, and its mask flag only chooses between servicing it and resuming inline. A wake from the reset pin always applies the restart delay, because reset forces the delay option back on.

Top module: `stop_wake_ctrl`

## Requirements
- R1: With `stop_dis_i` low, a one-cycle `stop_req_i` while running makes `busy_o` 1 and `clk_en_o` 0 from the next cycle on.
- R2: With `stop_dis_i` high, a stop request is ignored: `busy_o` stays 0 and `clk_en_o` stays 1.
- R3: While stopped with no accepted wake, the block stays stopped with `clk_en_o` 0. A low `irq_ni` while `i_mask_i` is 1 is not a wake.
- R4: A low `irq_ni` with `i_mask_i` 0 wakes the block with resume code 2'b01 (service interrupt).
- R5: A low `xirq_ni` always wakes the block. With `x_mask_i` 0 the code is 2'b01; with `x_mask_i` 1 the code is 2'b10 (continue inline).
- R6: A low `rst_pin_ni` always wakes the block with code 2'b11 (reset vector). It always applies the restart delay, even when `dly_en_i` is 0.
- R7: When several wake pins are low at once, the reset pin wins over `xirq_ni`, and `xirq_ni` wins over `irq_ni`.
- R8: If a pin goes low before clock edge e, `done_o` is 1 after edge e+2 when no delay applies. When `dly_en_i` is 1 or the wake is a reset, it is 1 after edge e+2+DELAY_CYC.
- R9: `done_o` lasts exactly one cycle. `resume_o` is 2'b00 whenever `done_o` is 0. `clk_en_o` is 1 and `busy_o` is 0 in the done cycle.
- R10: After `rst_ni` the block is running: `busy_o` 0, `clk_en_o` 1, `done_o` 0, `resume_o` 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| stop_req_i | input | 1 | Stop request from the instruction decoder |
| stop_dis_i | input | 1 | Stop-disable flag; when set, stop requests are ignored |
| i_mask_i | input | 1 | Mask flag for the maskable interrupt |
| x_mask_i | input | 1 | Mask flag for the high-priority interrupt |
| dly_en_i | input | 1 | Option bit that enables the restart delay |
| irq_ni | input | 1 | Maskable interrupt pin, active low |
| xirq_ni | input | 1 | High-priority interrupt pin, active low |
| rst_pin_ni | input | 1 | Reset pin used as a wake source, active low |
| clk_en_o | output | 1 | Core clock enable |
| busy_o | output | 1 | High while stopped or waiting out the restart delay |
| done_o | output | 1 | One-cycle strobe marking the return to running |
| resume_o | output | 2 | Resume code, valid together with done_o |

## Verification
Entry is due one edge after the request: the bench pulses `stop_req_i` for a single cycle and reads `busy_o` and `clk_en_o` at the next falling edge. A wake result is due three edges after the pin falls, or three edges plus DELAY_CYC when the delay applies. The bench drives pins on falling edges and counts rising edges until it sees `done_o`, then compares that count and the code with values its own functions compute. Masked or absent wakes are checked by holding the block for several cycles and confirming it is still stopped. Between trials, every pin is released and left alone long enough to flush the synchronizer.

// File: rtl/stop_wake_pkg.sv
package stop_wake_pkg;
  typedef enum logic [1:0] {
    RES_NONE    = 2'b00,
    RES_SERVICE = 2'b01,
    RES_INLINE  = 2'b10,
    RES_VECTOR  = 2'b11
  } resume_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'b00,
    ST_STOP  = 2'b01,
    ST_DELAY = 2'b10
  } state_e;

  // Bit positions of the synchronized wake vector
  localparam int unsigned W_IRQ  = 0;
  localparam int unsigned W_XIRQ = 1;
  localparam int unsigned W_RST  = 2;
  localparam int unsigned W_NUM  = 3;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_ni,
  output logic [WIDTH-1:0] sync_no
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;
      else         chain_q <= {chain_q[STAGES-2:0], pin_ni[b]};
    end
    assign sync_no[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/wake_arbiter.sv
module wake_arbiter
  import stop_wake_pkg::*;
(
  input  logic [W_NUM-1:0] wake_ni,
  input  logic             i_mask_i,
  input  logic             x_mask_i,
  input  logic             dly_en_i,
  output logic             wake_o,
  output resume_e          code_o,
  output logic             need_dly_o
);
  always_comb begin
    wake_o     = 1'b0;
    code_o     = RES_NONE;
    need_dly_o = dly_en_i;
    if (!wake_ni[W_RST]) begin
      wake_o     = 1'b1;
      code_o     = RES_VECTOR;
      need_dly_o = 1'b1;  // reset re-arms the delay option
    end else if (!wake_ni[W_XIRQ]) begin
      wake_o = 1'b1;
      code_o = x_mask_i ? RES_INLINE : RES_SERVICE;
    end else if (!wake_ni[W_IRQ] && !i_mask_i) begin
      wake_o = 1'b1;
      code_o = RES_SERVICE;
    end
  end
endmodule

// File: rtl/restart_timer.sv
module restart_timer #(
  parameter int unsigned LIMIT = 4064,
  localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
  import stop_wake_pkg::*;
#(
  parameter int unsigned DELAY_CYC = 4064
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stop_req_i,
  input  logic       stop_dis_i,
  input  logic       i_mask_i,
  input  logic       x_mask_i,
  input  logic       dly_en_i,
  input  logic       irq_ni,
  input  logic       xirq_ni,
  input  logic       rst_pin_ni,
  output logic       clk_en_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [1:0] resume_o
);
  logic [W_NUM-1:0] pins_n, sync_n;
  logic             wake, need_dly, tmr_exp;
  resume_e          wake_code, code_q;
  state_e           state_q, state_d;
  logic             done_q, done_d;
  resume_e          code_d;

  assign pins_n[W_IRQ]  = irq_ni;
  assign pins_n[W_XIRQ] = xirq_ni;
  assign pins_n[W_RST]  = rst_pin_ni;

  wake_sync #(.WIDTH(W_NUM), .STAGES(2)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_ni  (pins_n),
    .sync_no (sync_n)
  );

  wake_arbiter u_arb (
    .wake_ni    (sync_n),
    .i_mask_i   (i_mask_i),
    .x_mask_i   (x_mask_i),
    .dly_en_i   (dly_en_i),
    .wake_o     (wake),
    .code_o     (wake_code),
    .need_dly_o (need_dly)
  );

  restart_timer #(.LIMIT(DELAY_CYC)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (state_q == ST_DELAY),
    .expired_o (tmr_exp)
  );

  always_comb begin
    state_d = state_q;
    code_d  = code_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        code_d = RES_NONE;
        if (stop_req_i && !stop_dis_i) state_d = ST_STOP;
      end
      ST_STOP: begin
        if (wake) begin
          code_d = wake_code;
          if (need_dly) begin
            state_d = ST_DELAY;
          end else begin
            state_d = ST_RUN;
            done_d  = 1'b1;
          end
        end
      end
      ST_DELAY: begin
        if (tmr_exp) begin
          state_d = ST_RUN;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      code_q  <= RES_NONE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      code_q  <= code_d;
      done_q  <= done_d;
    end
  end

  assign clk_en_o = (state_q == ST_RUN);
  assign busy_o   = (state_q != ST_RUN);
  assign done_o   = done_q;
  assign resume_o = done_q ? code_q : RES_NONE;
endmodule

// File: rtl/stop_wake_ctrl_chk.sv
module stop_wake_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       stop_req_i,
  input logic       stop_dis_i,
  input logic       clk_en_o,
  input logic       busy_o,
  input logic       done_o,
  input logic [1:0] resume_o
);
  a_r1_enter_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && stop_req_i && !stop_dis_i) |=> (busy_o && !clk_en_o));

  a_r2_ignore_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && stop_req_i && stop_dis_i) |=> (!busy_o && clk_en_o));

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_code_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (resume_o == 2'b00));

  a_r9_done_clk_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (clk_en_o && !busy_o));

  a_r9_exit_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  a_r3_clk_off_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |-> !clk_en_o);
endmodule

bind stop_wake_ctrl stop_wake_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .stop_req_i (stop_req_i),
  .stop_dis_i (stop_dis_i),
  .clk_en_o   (clk_en_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .resume_o   (resume_o)
);

// File: tb/stop_wake_ctrl_bench.sv
`timescale 1ns/1ps
module stop_wake_ctrl_bench;
  localparam int unsigned DLY = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic stop_req = 0, stop_dis = 0, i_mask = 0, x_mask = 0, dly_en = 0;
  logic irq_n = 1, xirq_n = 1, rstp_n = 1;
  logic clk_en, busy, done;
  logic [1:0] resume;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  stop_wake_ctrl #(.DELAY_CYC(DLY)) u_stop_wake_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .stop_req_i(stop_req), .stop_dis_i(stop_dis),
    .i_mask_i(i_mask), .x_mask_i(x_mask), .dly_en_i(dly_en),
    .irq_ni(irq_n), .xirq_ni(xirq_n), .rst_pin_ni(rstp_n),
    .clk_en_o(clk_en), .busy_o(busy), .done_o(done), .resume_o(resume)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pins {rst,xirq,irq} active-high here: 1 = pulled low
  function automatic bit exp_wake(input logic [2:0] p, input logic im);
    return p[2] || p[1] || (p[0] && !im);
  endfunction

  function automatic int exp_code(input logic [2:0] p, input logic xm);
    if (p[2]) return 3;
    if (p[1]) return xm ? 2 : 1;
    return 1;
  endfunction

  function automatic int exp_lat(input logic [2:0] p, input logic de);
    return (p[2] || de) ? 3 + DLY : 3;
  endfunction

  task automatic release_pins();
    irq_n = 1; xirq_n = 1; rstp_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic request(input logic dis);
    stop_dis = dis; stop_req = 1;
    @(negedge clk);
    stop_req = 0;
  endtask

  // drive pins and count edges until done; returns latency or -1
  task automatic wake_and_measure(input logic [2:0] p, output int lat, output int code);
    rstp_n = !p[2]; xirq_n = !p[1]; irq_n = !p[0];
    lat = -1; code = 0;
    for (int n = 1; n <= 3 * DLY + 10; n++) begin
      @(negedge clk);
      if (done) begin lat = n; code = resume; break; end
    end
  endtask

  task automatic trial(input logic [2:0] p, input logic im, input logic xm, input logic de);
    int lat, code;
    i_mask = im; x_mask = xm; dly_en = de;
    request(1'b0);
    chk("R1 busy after request", busy, 1);
    chk("R1 clk_en off", clk_en, 0);
    if (!exp_wake(p, im)) begin
      rstp_n = !p[2]; xirq_n = !p[1]; irq_n = !p[0];
      repeat (8) @(negedge clk);
      chk("R3 still stopped", busy, 1);
      chk("R3 clk still off", clk_en, 0);
      release_pins();
      p = 3'b100;
    end
    wake_and_measure(p, lat, code);
    chk("R8 wake latency", lat, exp_lat(p, de));
    chk("R7 resume code", code, exp_code(p, xm));
    chk("R9 clk on with done", clk_en, 1);
    @(negedge clk);
    chk("R9 done single cycle", done, 0);
    chk("R9 code cleared", resume, 0);
    release_pins();
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 busy at reset", busy, 0);
    chk("R10 clk_en at reset", clk_en, 1);
    chk("R10 done at reset", done, 0);
    chk("R10 code at reset", resume, 0);

    request(1'b1);
    chk("R2 ignored busy", busy, 0);
    chk("R2 ignored clk_en", clk_en, 1);

    trial(3'b001, 0, 0, 0);  // R4 maskable, no delay
    trial(3'b010, 0, 0, 0);  // R5 x clear -> service
    trial(3'b010, 0, 1, 1);  // R5 x set -> inline, with delay
    trial(3'b100, 0, 0, 0);  // R6 reset forces delay
    trial(3'b001, 1, 0, 0);  // R3 masked irq, then reset
    trial(3'b111, 0, 1, 0);  // R7 reset wins
    trial(3'b011, 0, 1, 0);  // R7 xirq over irq

    for (int t = 0; t < 40; t++) begin
      logic [2:0] p;
      p = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 4) == 0) begin
        request(1'b1);
        chk("R2 random ignored", busy, 0);
      end
      trial(p, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule